// File: doc/BRIEF.md
# Block-protocol serial configuration slave

This block is a two-wire serial slave that gives a host strictly sequential access to a small bank of 8-bit configuration registers. It has no register pointer. A write names the write address and then sends two header bytes, a command code and a byte count, which the slave acknowledges and throws away. The data bytes that follow fill the registers from index 0 upward until the host ends the transfer. A read names the read address. The slave then sends the number of implemented registers, followed by the registers from index 0 upward, for as long as the host keeps acknowledging.

The bus lines are oversampled on a system clock that runs at least 20 times faster than the bit rate. They pass through a two-flop synchroniser, and start and stop conditions are found from edges of the synchronised lines. The slave pulls SDA low through an open-drain enable, and never drives it high. The register contents are presented in parallel so that the surrounding logic can use them directly.

Top module: `cfg_block_slave`

## Requirements
- R1: After reset, register k holds its default, where the defaults for k = 0..6 are 12h, A5h, 00h, FFh, 7Fh, C7h, 3Fh. regs_o carries register k on bits [8k+7:8k]. sda_oe_o is 0 after reset.
- R2: The slave acknowledges address byte D2h as a write and D3h as a read. Acknowledging means sda_oe_o is 1 while SCL is high on the ninth clock. Any other address byte is not acknowledged, SDA stays released, and no register changes until the next start.
- R3: On a write, the two bytes after the address are acknowledged and discarded. Each later byte is acknowledged and loads the next register, starting at register 0.
- R4: If the host stops after any complete data byte, the registers already loaded keep their new values and every later register keeps its previous value.
- R5: Data bytes beyond register 6 are acknowledged and change no register.
- R6: Bit 7 of register 4 and bits 7:6 of register 6 are read-only. They keep their defaults whatever is written to them.
- R7: On a read, the slave first sends the byte count 07h, then registers 0, 1, 2 and so on. Every byte is sent MSB first.
- R8: Read bytes requested past register 6 come back as FFh, because SDA stays released.
- R9: After the host NACKs a read byte, the slave keeps SDA released until the next start.
- R10: A start condition in the middle of a byte aborts the transfer and restarts address reception. The partial byte is discarded and registers written earlier are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 20 times the bus bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low |
| regs_o | output | 56 | Register bank; register k on bits [8k+7:8k] |

## Verification
Two functions can fall on the same bus event. In the first, a start condition arrives while a data byte is half shifted in, so the abort must win over byte completion. The bench provokes this by sending four bits of a write byte and then issuing a repeated start followed by a read. The read must return the bytes that were completed before the abort, and the target of the partial byte must keep its old value. In the second, the write that follows the last implemented register coincides with the counter that counts bytes past the end. The bench checks this by sending up to twelve data bytes and comparing both regs_o and the read-back against a model that ignores every byte past register 6.

// File: rtl/cfg_slave_pkg.sv
package cfg_slave_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_OUT,
    ST_TX,
    ST_ACK_IN
  } bus_state_e;
endpackage

// File: rtl/cfg_bus_sync.sv
module cfg_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s      = scl_q[STAGES-1];
  assign sda_o      = sda_q[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // conditions only while SCL is steady high
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/cfg_bus_ctrl.sv
module cfg_bus_ctrl
  import cfg_slave_pkg::*;
#(
  parameter int          NUM_REGS = 7,
  parameter int          CW       = 5,
  parameter logic [7:0]  WR_ADDR  = 8'hD2,
  parameter logic [7:0]  RD_ADDR  = 8'hD3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sda_i,
  input  logic                  scl_rise_i,
  input  logic                  scl_fall_i,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic [NUM_REGS*8-1:0] regs_i,
  output logic                  sda_oe_o,
  output logic                  wr_valid_o,
  output logic [CW-1:0]         wr_idx_o,
  output logic [7:0]            wr_data_o,
  output logic                  rd_mode_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] HDR_LEN = CW'(2);
  localparam logic [CW-1:0] W_END   = CW'(NUM_REGS + 2);

  bus_state_e  state_q;
  logic [3:0]  bit_cnt_q;
  logic [7:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic        is_addr_q, is_read_q, nack_q;
  logic [7:0]  tx_byte;

  // byte 0 of a read is the count, then the registers, then released bus
  always_comb begin
    tx_byte = 8'hFF;
    if (cnt_q == '0) tx_byte = 8'(NUM_REGS);
    for (int i = 0; i < NUM_REGS; i++)
      if (cnt_q == CW'(i + 1)) tx_byte = regs_i[i*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      cnt_q      <= '0;
      is_addr_q  <= 1'b0;
      is_read_q  <= 1'b0;
      nack_q     <= 1'b0;
      sda_oe_o   <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_idx_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      if (start_i) begin
        state_q   <= ST_RX;
        bit_cnt_q <= '0;
        is_addr_q <= 1'b1;
        is_read_q <= 1'b0;
        sda_oe_o  <= 1'b0;
      end else if (stop_i) begin
        state_q   <= ST_IDLE;
        is_read_q <= 1'b0;
        sda_oe_o  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise_i && bit_cnt_q != 4'd8) begin
              sh_q      <= {sh_q[6:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
              bit_cnt_q <= '0;
              if (is_addr_q) begin
                is_addr_q <= 1'b0;
                cnt_q     <= '0;
                if (sh_q == WR_ADDR || sh_q == RD_ADDR) begin
                  is_read_q <= (sh_q == RD_ADDR);
                  sda_oe_o  <= 1'b1;
                  state_q   <= ST_ACK_OUT;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                sda_oe_o <= 1'b1;
                state_q  <= ST_ACK_OUT;
                if (cnt_q >= HDR_LEN && cnt_q < W_END) begin
                  wr_valid_o <= 1'b1;
                  wr_idx_o   <= cnt_q - HDR_LEN;
                  wr_data_o  <= sh_q;
                end
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_ACK_OUT: begin
            if (scl_fall_i) begin
              if (is_read_q) begin
                sh_q      <= tx_byte;
                sda_oe_o  <= ~tx_byte[7];
                bit_cnt_q <= 4'd1;
                state_q   <= ST_TX;
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
              end else begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (bit_cnt_q == 4'd8) begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_ACK_IN;
              end else begin
                sda_oe_o  <= ~sh_q[6];
                sh_q      <= {sh_q[6:0], 1'b0};
                bit_cnt_q <= bit_cnt_q + 4'd1;
              end
            end
          end
          ST_ACK_IN: begin
            if (scl_rise_i) nack_q <= sda_i;
            if (scl_fall_i) begin
              if (nack_q) begin
                state_q <= ST_IDLE;
              end else begin
                sh_q      <= tx_byte;
                sda_oe_o  <= ~tx_byte[7];
                bit_cnt_q <= 4'd1;
                state_q   <= ST_TX;
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          default: sda_oe_o <= 1'b0;
        endcase
      end
    end
  end

  assign rd_mode_o = is_read_q;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int                    NUM_REGS = 7,
  parameter int                    CW       = 5,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS = '0,
  parameter logic [NUM_REGS*8-1:0] WMASK    = '1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_valid_i,
  input  logic [CW-1:0]         wr_idx_i,
  input  logic [7:0]            wr_data_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] DEF = DEFAULTS[g*8 +: 8];
    localparam logic [7:0] MSK = WMASK[g*8 +: 8];
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= DEF;
      else if (wr_valid_i && wr_idx_i == CW'(g))
        q <= (wr_data_i & MSK) | (DEF & ~MSK);
    end
    assign regs_o[g*8 +: 8] = q;
  end
endmodule

// File: rtl/cfg_block_slave.sv
module cfg_block_slave #(
  parameter int                    NUM_REGS    = 7,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [7:0]            WR_ADDR     = 8'hD2,
  parameter logic [7:0]            RD_ADDR     = 8'hD3,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS    = 56'h3F_C7_7F_FF_00_A5_12,
  parameter logic [NUM_REGS*8-1:0] WMASK       = 56'h3F_FF_7F_FF_FF_FF_FF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int CW = $clog2(NUM_REGS + 3) + 1;

  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          wr_valid, rd_mode;
  logic [CW-1:0] wr_idx;
  logic [7:0]    wr_data;

  cfg_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  cfg_bus_ctrl #(
    .NUM_REGS(NUM_REGS), .CW(CW), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)
  ) i_ctrl (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .regs_i(regs_o),
    .sda_oe_o, .wr_valid_o(wr_valid), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .rd_mode_o(rd_mode)
  );

  cfg_reg_bank #(
    .NUM_REGS(NUM_REGS), .CW(CW), .DEFAULTS(DEFAULTS), .WMASK(WMASK)
  ) i_regs (
    .clk_i, .rst_ni, .wr_valid_i(wr_valid), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .regs_o
  );
endmodule

// File: rtl/cfg_block_slave_chk.sv
module cfg_block_slave_chk #(
  parameter int                    NUM_REGS = 7,
  parameter int                    CW       = 5,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS = '0,
  parameter logic [NUM_REGS*8-1:0] WMASK    = '1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sda_oe_o,
  input logic [NUM_REGS*8-1:0] regs_o,
  input logic                  wr_valid,
  input logic [CW-1:0]         wr_idx,
  input logic                  rd_mode,
  input logic                  start_det,
  input logic                  stop_det
);
  assert_ro_bits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_o & ~WMASK) == (DEFAULTS & ~WMASK));

  assert_wr_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid |-> wr_idx < CW'(NUM_REGS));

  assert_regs_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid |=> $stable(regs_o));

  assert_no_write_in_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_mode |-> !wr_valid);

  assert_release_on_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o);

  assert_release_on_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);
endmodule

bind cfg_block_slave cfg_block_slave_chk #(
  .NUM_REGS(NUM_REGS), .CW(CW), .DEFAULTS(DEFAULTS), .WMASK(WMASK)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_o(sda_oe_o), .regs_o(regs_o),
  .wr_valid(wr_valid), .wr_idx(wr_idx), .rd_mode(rd_mode),
  .start_det(start_det), .stop_det(stop_det)
);

// File: tb/test_cfg_block_slave.sv
module test_cfg_block_slave;
  localparam int Q = 6;
  localparam logic [55:0] DEF = 56'h3F_C7_7F_FF_00_A5_12;
  localparam logic [55:0] MSK = 56'h3F_FF_7F_FF_FF_FF_FF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [55:0] regs;
  logic sda_line;
  logic done = 1'b0;
  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_q [7];

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  cfg_block_slave i_cfg_block_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  function automatic logic [55:0] exp_flat();
    logic [55:0] f;
    for (int i = 0; i < 7; i++) f[i*8 +: 8] = exp_q[i];
    return f;
  endfunction

  function automatic logic [7:0] merge(input int k, input logic [7:0] d);
    return (d & MSK[k*8 +: 8]) | (DEF[k*8 +: 8] & ~MSK[k*8 +: 8]);
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b, output logic r);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    r = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack_n);
    logic r;
    for (int i = 7; i >= 0; i--) put_bit(b[i], r);
    put_bit(1'b1, ack_n);
  endtask

  task automatic rd_byte(input logic ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin put_bit(1'b1, r); d[i] = r; end
    put_bit(~ack, r);
  endtask

  task automatic do_write(input int n);
    logic a;
    logic [7:0] d;
    bus_start();
    wr_byte(8'hD2, a); chk(a, 0, "R2 write address ack");
    wr_byte(8'($urandom), a); chk(a, 0, "R3 command ack");
    wr_byte(8'($urandom), a); chk(a, 0, "R3 count ack");
    for (int j = 0; j < n; j++) begin
      d = 8'($urandom);
      wr_byte(d, a);
      if (j < 7) begin
        chk(a, 0, "R3 data ack");
        exp_q[j] = merge(j, d);
      end else chk(a, 0, "R5 surplus ack");
    end
    bus_stop();
    chk(regs, exp_flat(), "R4 regs after stop");
    chk(regs & ~MSK, DEF & ~MSK, "R6 read-only bits");
  endtask

  task automatic do_read(input int k);
    logic a;
    logic [7:0] d;
    bus_start();
    wr_byte(8'hD3, a); chk(a, 0, "R2 read address ack");
    rd_byte(k > 0, d); chk(d, 8'h07, "R7 byte count");
    for (int j = 0; j < k; j++) begin
      rd_byte(j < k - 1, d);
      if (j < 7) chk(d, exp_q[j], "R7 read data");
      else chk(d, 8'hFF, "R8 past last register");
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic a, r;
    logic [7:0] d, bad;
    void'($urandom(32'd2024));
    for (int i = 0; i < 7; i++) exp_q[i] = DEF[i*8 +: 8];
    tick(5); rst_n = 1'b1; tick(5);
    chk(regs, DEF, "R1 reset defaults");
    chk(sda_oe, 0, "R1 sda released");

    do_write(7);
    do_read(7);

    for (int it = 0; it < 10; it++) begin
      do_write(int'($urandom_range(0, 12)));
      if (it % 2 == 1) do_read(int'($urandom_range(1, 9)));
    end

    // foreign address
    do begin bad = 8'($urandom); end while (bad == 8'hD2 || bad == 8'hD3);
    bus_start();
    wr_byte(bad, a); chk(a, 1, "R2 foreign address no ack");
    wr_byte(8'h00, a); chk(a, 1, "R2 bus stays released");
    wr_byte(8'h00, a);
    bus_stop();
    chk(regs, exp_flat(), "R2 regs untouched");

    // host NACK on byte count, then slave must stay off the bus
    bus_start();
    wr_byte(8'hD3, a); chk(a, 0, "R2 read address ack");
    rd_byte(1'b0, d); chk(d, 8'h07, "R7 count before nack");
    rd_byte(1'b1, d); chk(d, 8'hFF, "R9 released after nack");
    bus_stop();

    // abort mid byte with repeated start
    bus_start();
    wr_byte(8'hD2, a);
    wr_byte(8'h00, a);
    wr_byte(8'h00, a);
    d = 8'($urandom); wr_byte(d, a); exp_q[0] = merge(0, d);
    d = 8'($urandom); wr_byte(d, a); exp_q[1] = merge(1, d);
    for (int i = 0; i < 4; i++) put_bit(1'($urandom), r);
    bus_start();
    wr_byte(8'hD3, a); chk(a, 0, "R10 address after abort");
    rd_byte(1'b1, d); chk(d, 8'h07, "R10 count after abort");
    for (int j = 0; j < 3; j++) begin
      rd_byte(j < 2, d); chk(d, exp_q[j], "R10 kept and untouched regs");
    end
    bus_stop();
    chk(regs, exp_flat(), "R10 regs after abort");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule